// File: doc/BRIEF.md
# Three-Port Byte-Stream Packet Router

The router takes packets arriving one byte per cycle on a single input and forwards each one to one of three output ports. The first byte of a packet is a header. Its two low bits name the destination port, and its six high bits give the number of payload bytes. The payload follows the header. The packet closes with a check byte, which is the XOR of the header and all payload bytes. The sender keeps the input valid strobe high for the header and the payload. It drops the strobe on the cycle that carries the check byte, and that cycle ends the packet.

The router stores the whole packet in a one-packet buffer and checks the XOR as the last byte arrives. A packet that passes the check is replayed on its port with the same framing. A packet with a bad check byte, or one addressed to port 3, is thrown away and reported with a one-cycle pulse. The router raises its input hold while it owns an undelivered packet. Each output consumer keeps its own hold high until it is ready. Output bytes advance only on cycles where that port's hold is low.

Top module: `pkt_router3`

## Requirements
- R1: Header bits [1:0] select the output port (0, 1 or 2), and header bits [7:2] give the payload length in bytes. The packet appears on the port named by the header.
- R2: A packet that is accepted appears on its port as the header, then the payload bytes in order, then the check byte. The port's valid is high for the header and payload and low for the check byte.
- R3: At most one output valid is high at any time. Ports that are not sending drive all-zero data.
- R4: A port moves on to its next byte only at a clock edge where that port's hold input is low. While hold is high, the presented byte and valid stay unchanged.
- R5: The input hold goes high on the cycle after the check byte of an accepted packet. It stays high until the cycle after that packet's check byte has been taken at the output. Outside that span it is low.
- R6: A packet whose check byte differs from the XOR of its header and payload bytes is dropped and never shows on any port. In the cycle after its check byte, `drop_pulse` is high for exactly one cycle and the input hold stays low.
- R7: A packet whose header address is 3 is dropped in the same way as in R6, with a single `drop_pulse` and no output.
- R8: While reset is asserted, the input hold, all output valids and `drop_pulse` are low, and all output data is zero.
- R9: Payload lengths from 1 to 63 bytes are buffered and replayed complete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| in_data | input | 8 | Input byte |
| in_valid | input | 1 | High on header and payload bytes, low on the check byte |
| in_hold | output | 1 | Backpressure to the sender; no new byte while high |
| out_data | output | 3x8 | Per-port output byte, zero when the port is idle |
| out_valid | output | 3 | Per-port valid, high on header and payload bytes |
| out_hold | input | 3 | Per-port consumer hold; a byte moves only when low |
| drop_pulse | output | 1 | One-cycle pulse for each discarded packet |

## Verification
The assertions assume that the sender respects `in_hold`. They also assume that each packet's framing matches its header length and never exceeds 63 payload bytes. Consumers may raise or lower their holds on any cycle.

The stimulus sends bytes only on cycles where `in_hold` was sampled low, and it builds every packet from its header so that the framing always agrees. The holds on the output ports are randomized freely, including stalls in the middle of a packet and idle ports that toggle at random, so the assertions about stalled data are exercised without any guarantee the block depends on.

// File: rtl/pr_pkg.sv
package pr_pkg;

  typedef enum logic [1:0] {
    ING_IDLE = 2'd0,
    ING_BODY = 2'd1,
    ING_FULL = 2'd2
  } ing_state_e;

endpackage

// File: rtl/pr_rst_sync.sv
module pr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/pr_pkt_buf.sv
module pr_pkt_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 65,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [PW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/pr_ingress.sv
module pr_ingress
  import pr_pkg::*;
#(
  parameter int DW      = 8,
  parameter int ADDR_W  = 2,
  parameter int N_PORTS = 3,
  parameter int DEPTH   = 65,
  parameter int PW      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     in_data,
  input  logic              in_valid,
  input  logic              done,
  output logic              wr_en,
  output logic [PW-1:0]     wr_addr,
  output logic [DW-1:0]     wr_data,
  output logic              busy,
  output logic [ADDR_W-1:0] dest,
  output logic [PW-1:0]     last_idx,
  output logic              drop_pulse
);

  localparam logic [PW-1:0] PTR_MAX = PW'(DEPTH - 1);
  localparam logic [PW-1:0] PTR_ONE = PW'(1);

  ing_state_e        state_q, state_d;
  logic [PW-1:0]     wr_ptr_q, wr_ptr_d;
  logic [DW-1:0]     acc_q, acc_d;
  logic [ADDR_W-1:0] dest_q, dest_d;
  logic [PW-1:0]     last_q, last_d;
  logic              drop_q, drop_d;
  logic              pkt_ok;

  // A packet passes when the running XOR equals the closing byte and the
  // destination is a real port.
  assign pkt_ok = (acc_q == in_data) && (int'(dest_q) < N_PORTS);

  always_comb begin
    state_d  = state_q;
    wr_ptr_d = wr_ptr_q;
    acc_d    = acc_q;
    dest_d   = dest_q;
    last_d   = last_q;
    drop_d   = 1'b0;
    wr_en    = 1'b0;
    wr_addr  = wr_ptr_q;
    wr_data  = in_data;
    unique case (state_q)
      ING_IDLE: begin
        if (in_valid) begin
          wr_en    = 1'b1;
          wr_addr  = '0;
          wr_ptr_d = PTR_ONE;
          acc_d    = in_data;
          dest_d   = in_data[ADDR_W-1:0];
          state_d  = ING_BODY;
        end
      end
      ING_BODY: begin
        wr_en = 1'b1;
        if (in_valid) begin
          acc_d = acc_q ^ in_data;
          if (wr_ptr_q < PTR_MAX) begin
            wr_ptr_d = wr_ptr_q + PTR_ONE;
          end
        end else if (pkt_ok) begin
          last_d  = wr_ptr_q;
          state_d = ING_FULL;
        end else begin
          drop_d  = 1'b1;
          state_d = ING_IDLE;
        end
      end
      ING_FULL: begin
        if (done) begin
          state_d = ING_IDLE;
        end
      end
      default: state_d = ING_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ING_IDLE;
      wr_ptr_q <= '0;
      acc_q    <= '0;
      dest_q   <= '0;
      last_q   <= '0;
      drop_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      wr_ptr_q <= wr_ptr_d;
      acc_q    <= acc_d;
      dest_q   <= dest_d;
      last_q   <= last_d;
      drop_q   <= drop_d;
    end
  end

  assign busy       = (state_q == ING_FULL);
  assign dest       = dest_q;
  assign last_idx   = last_q;
  assign drop_pulse = drop_q;

endmodule

// File: rtl/pr_egress.sv
module pr_egress #(
  parameter int DW      = 8,
  parameter int ADDR_W  = 2,
  parameter int N_PORTS = 3,
  parameter int PW      = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       busy,
  input  logic [ADDR_W-1:0]          dest,
  input  logic [PW-1:0]              last_idx,
  input  logic [DW-1:0]              rd_data,
  input  logic [N_PORTS-1:0]         out_hold,
  output logic [PW-1:0]              rd_addr,
  output logic                       done,
  output logic [N_PORTS-1:0][DW-1:0] out_data,
  output logic [N_PORTS-1:0]         out_valid
);

  logic [PW-1:0]      rd_q, rd_d;
  logic [N_PORTS-1:0] port_hit;
  logic               hold_sel;
  logic               xfer;
  logic               at_last;

  for (genvar g = 0; g < N_PORTS; g++) begin : g_port
    assign port_hit[g]  = busy && (dest == ADDR_W'(g));
    assign out_valid[g] = port_hit[g] && !at_last;
    assign out_data[g]  = port_hit[g] ? rd_data : '0;
  end

  assign hold_sel = |(port_hit & out_hold);
  assign at_last  = (rd_q == last_idx);
  assign xfer     = busy && !hold_sel;
  assign done     = xfer && at_last;

  always_comb begin
    rd_d = rd_q;
    if (!busy || done) begin
      rd_d = '0;
    end else if (xfer) begin
      rd_d = rd_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end

  assign rd_addr = rd_q;

endmodule

// File: rtl/pkt_router3.sv
module pkt_router3 #(
  parameter int DW      = 8,
  parameter int ADDR_W  = 2,
  parameter int N_PORTS = 3,
  parameter int MAX_LEN = 63
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [DW-1:0]              in_data,
  input  logic                       in_valid,
  output logic                       in_hold,
  output logic [N_PORTS-1:0][DW-1:0] out_data,
  output logic [N_PORTS-1:0]         out_valid,
  input  logic [N_PORTS-1:0]         out_hold,
  output logic                       drop_pulse
);

  localparam int DEPTH = MAX_LEN + 2;
  localparam int PW    = $clog2(DEPTH);

  logic              rst_sync_n;
  logic              wr_en;
  logic [PW-1:0]     wr_addr;
  logic [DW-1:0]     wr_data;
  logic [PW-1:0]     rd_addr;
  logic [DW-1:0]     rd_data;
  logic              busy;
  logic              done;
  logic [ADDR_W-1:0] dest;
  logic [PW-1:0]     last_idx;

  pr_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pr_ingress #(
    .DW(DW), .ADDR_W(ADDR_W), .N_PORTS(N_PORTS), .DEPTH(DEPTH), .PW(PW)
  ) i_ingress (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .in_data    (in_data),
    .in_valid   (in_valid),
    .done       (done),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .busy       (busy),
    .dest       (dest),
    .last_idx   (last_idx),
    .drop_pulse (drop_pulse)
  );

  pr_pkt_buf #(
    .DW(DW), .DEPTH(DEPTH), .PW(PW)
  ) i_buf (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  pr_egress #(
    .DW(DW), .ADDR_W(ADDR_W), .N_PORTS(N_PORTS), .PW(PW)
  ) i_egress (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .busy      (busy),
    .dest      (dest),
    .last_idx  (last_idx),
    .rd_data   (rd_data),
    .out_hold  (out_hold),
    .rd_addr   (rd_addr),
    .done      (done),
    .out_data  (out_data),
    .out_valid (out_valid)
  );

  assign in_hold = busy;

endmodule

// File: rtl/pr_router_chk.sv
module pr_router_chk #(
  parameter int DW      = 8,
  parameter int N_PORTS = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_hold,
  input logic [N_PORTS-1:0][DW-1:0] out_data,
  input logic [N_PORTS-1:0]         out_valid,
  input logic [N_PORTS-1:0]         out_hold,
  input logic                       drop_pulse
);

  // R3: only one port sends at a time
  a_r3_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_valid));

  // R6: a discard is flagged for a single cycle
  a_r6_drop_single: assert property (@(posedge clk) disable iff (!rst_n)
    drop_pulse |=> !drop_pulse);

  // R6 and R7: a discarded packet never blocks the sender
  a_r6_drop_frees_input: assert property (@(posedge clk) disable iff (!rst_n)
    drop_pulse |-> !in_hold);

  // R5: input hold is released only after the closing byte slot
  a_r5_release_after_close: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_hold) |-> ($past(out_valid) == '0));

  for (genvar g = 0; g < N_PORTS; g++) begin : g_chk
    // R4: a held port keeps its byte
    a_r4_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[g] && out_hold[g]) |=> (out_valid[g] && $stable(out_data[g])));

    // R5: a port only sends while the input is held off
    a_r5_valid_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[g] |-> in_hold);
  end

endmodule

bind pkt_router3 pr_router_chk #(.DW(DW), .N_PORTS(N_PORTS)) i_router_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_hold    (in_hold),
  .out_data   (out_data),
  .out_valid  (out_valid),
  .out_hold   (out_hold),
  .drop_pulse (drop_pulse)
);

// File: tb/test_pkt_router3.sv
`timescale 1ns/1ps
module test_pkt_router3;

  localparam int NP = 3;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [7:0]           in_data;
  logic                 in_valid;
  logic                 in_hold;
  logic [NP-1:0][7:0]   out_data;
  logic [NP-1:0]        out_valid;
  logic [NP-1:0]        out_hold;
  logic                 drop_pulse;

  int n_chk = 0;
  int n_bad = 0;
  logic [10:0] exq[$];   // {port, valid, byte}
  int  cst = 0;          // consumer: 0 wait, 1 delay, 2 transfer
  bit  go = 1'b0;

  always #2.5 clk = ~clk;

  pkt_router3 i_pkt_router3 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_hold(in_hold), .out_data(out_data), .out_valid(out_valid),
    .out_hold(out_hold), .drop_pulse(drop_pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] xor_all(input logic [7:0] b[$], input int n);
    logic [7:0] r = 8'h00;
    for (int i = 0; i < n; i++) r ^= b[i];
    return r;
  endfunction

  task automatic send_pkt(input int addr, input int len, input bit corrupt);
    logic [7:0] b[$];
    logic [7:0] p;
    bit good;
    b.push_back({len[5:0], addr[1:0]});
    for (int i = 0; i < len; i++) b.push_back(8'($urandom));
    p = xor_all(b, b.size());
    if (corrupt) p ^= 8'h10;
    b.push_back(p);
    good = (addr < 3) && !corrupt;
    if (good)
      for (int i = 0; i < b.size(); i++)
        exq.push_back({addr[1:0], (i < b.size() - 1), b[i]});
    for (int i = 0; i < b.size(); i++) begin
      @(negedge clk);
      while (in_hold) @(negedge clk);
      in_data  = b[i];
      in_valid = (i < b.size() - 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    if (good) begin
      check(in_hold == 1'b1, "R5 hold after accepted packet", in_hold, 1);
      check(drop_pulse == 1'b0, "R6 no drop on good packet", drop_pulse, 0);
    end else begin
      check(drop_pulse == 1'b1, corrupt ? "R6 drop on bad check byte" : "R7 drop on address 3",
            drop_pulse, 1);
      check(in_hold == 1'b0, "R6 hold stays low after drop", in_hold, 0);
    end
    repeat ($urandom % 3) @(negedge clk);
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 4000 && !(exq.size() == 0 && cst == 0); i++) @(negedge clk);
  endtask

  // Consumer for all three ports
  initial begin : consumer
    int port = 0;
    int cnt = 0;
    bit stalled = 1'b0;
    logic [10:0] e;
    wait (go);
    forever begin
      @(negedge clk);
      if (cst == 0) begin
        out_hold = NP'($urandom);
        if (out_valid != '0) begin
          check($countones(out_valid) == 1, "R3 one valid port", out_valid, 1);
          port = 0;
          for (int g = 0; g < NP; g++) if (out_valid[g]) port = g;
          for (int g = 0; g < NP; g++)
            if (g != port) check(out_data[g] == 8'h00, "R3 idle port data zero", out_data[g], 0);
          if (exq.size() == 0) begin
            check(1'b0, "R6 unexpected output packet", port, 0);
          end else begin
            e = exq[0];
            check(int'(e[10:9]) == port, "R1 packet on addressed port", port, e[10:9]);
          end
          out_hold[port] = 1'b1;
          cnt = ($urandom % 10 == 0) ? 150 + ($urandom % 250) : ($urandom % 6);
          stalled = 1'b0;
          cst = 1;
        end
      end else begin
        for (int g = 0; g < NP; g++) if (g != port) out_hold[g] = 1'($urandom);
        if (cst == 1 && cnt > 0) begin
          cnt--;
          out_hold[port] = 1'b1;
        end else if (cst == 2 && ($urandom % 4 == 0)) begin
          out_hold[port] = 1'b1;
          stalled = 1'b1;
        end else begin
          cst = 2;
          out_hold[port] = 1'b0;
          if (exq.size() == 0) begin
            check(1'b0, "R2 byte with nothing expected", out_data[port], 0);
            cst = 0;
          end else begin
            e = exq.pop_front();
            check({out_valid[port], out_data[port]} == e[8:0],
                  stalled ? "R4 byte held across stall" : "R2 byte and valid in order",
                  {out_valid[port], out_data[port]}, e[8:0]);
            stalled = 1'b0;
            if (!e[8]) cst = 0;
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4711));
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = 8'h00;
    out_hold = '1;
    repeat (3) @(negedge clk);
    check(in_hold == 1'b0, "R8 reset hold low", in_hold, 0);
    check(out_valid == '0, "R8 reset valids low", out_valid, 0);
    check(drop_pulse == 1'b0, "R8 reset drop low", drop_pulse, 0);
    check(out_data == '0, "R8 reset data zero", out_data[0], 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    go = 1'b1;

    send_pkt(0, 1, 1'b0);
    wait_drain();
    check(exq.size() == 0, "R9 shortest payload delivered", exq.size(), 0);
    send_pkt(1, 63, 1'b0);
    wait_drain();
    check(exq.size() == 0, "R9 longest payload delivered", exq.size(), 0);
    send_pkt(2, 7, 1'b0);
    send_pkt(3, 4, 1'b0);
    send_pkt(1, 10, 1'b1);
    send_pkt(0, 63, 1'b1);
    send_pkt(3, 63, 1'b0);
    send_pkt(2, 1, 1'b0);

    for (int k = 0; k < 60; k++)
      send_pkt($urandom % 4, 1 + ($urandom % 63), ($urandom % 6) == 0);

    wait_drain();
    check(exq.size() == 0, "R2 all accepted packets delivered", exq.size(), 0);
    repeat (3) @(negedge clk);
    check(in_hold == 1'b0, "R5 hold low when idle", in_hold, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule